// File: doc/BRIEF.md
# Dual-Channel UART Host Bus Front End

This block sits between a host processor bus and the two register banks of a dual-channel UART. The bus side uses a chip select, a one-bit channel select, a three-bit register address, an eight-bit write data word and separate active-low read and write strobes. All bus inputs pass through a synchronizer into the core clock domain. An edge detector then turns each bus access into exactly one single-cycle strobe towards the chosen channel. That strobe comes with the register address and, for writes, the data word. Read data returns through a multiplexer that drives the host data only while a read to the block is in progress.

A broadcast mode lets one write reach the same register in both channels at once, which shortens initialisation. Each channel also has a multi-function pin. Two selection bits route it to the inverted modem-control output bit, to the 16x baud tick, or to an active-low receive-ready flag for a DMA engine. The block produces the active-low transmit-ready flag with hysteresis. It also gates each channel's interrupt request with the modem-control output bit. The register contents of the channels live outside this block.

Top module: `duart_host_front`

## Requirements
- R1: With `cs_n` low, `chan_sel` = 1 addresses channel A (strobe bit 0) and `chan_sel` = 0 addresses channel B (strobe bit 1). With `cs_n` high, no strobe is produced for any access.
- R2: When bit 0 of either channel's `afr` field is 1, a write strobes both channels (`wr_stb` = 2'b11) in the same cycle, whatever `chan_sel` is.
- R3: A write produces one single-cycle `wr_stb` pulse per rising edge of `wr_n`, with `reg_addr` and `reg_wdata` holding the address and data presented on the bus.
- R4: A read produces one single-cycle `rd_stb` pulse per falling edge of `wr_n`'s read counterpart `rd_n`. While `rd_n` and `cs_n` are low, `host_rdata` carries the addressed channel's `ch_rdata`; otherwise it is zero.
- R5: In broadcast mode, a read strobes only channel A and returns channel A's data.
- R6: `afr` bits [2:1] select the MF pin function: 00 = OP, 01 = baud tick, 10 = receive-ready, 11 = constant high.
- R7: In OP mode, `mf_pin` is the inverse of `mcr_bit3`.
- R8: In receive-ready mode, `mf_pin` is low when `rx_level` is non-zero and high when it is zero.
- R9: `txrdy_n` goes high when `tx_free` is 0, goes low when `tx_free` >= `tx_trig`, and otherwise keeps its previous value.
- R10: `irq_out` follows `irq_req` only while `mcr_bit3` is 1, and it stays low during reset.
- R11: During reset, all strobes are zero, `host_rdata` is zero, `mf_pin` is low and `txrdy_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| chan_sel | input | 1 | 1 = channel A, 0 = channel B |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, captured on rising edge |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data from host |
| ch_rdata | input | 2x8 | Read data from each channel's registers (index 0 = A) |
| afr | input | 2x3 | Per-channel alternate-function bits: [0] broadcast, [2:1] MF select |
| mcr_bit3 | input | 2 | Per-channel modem-control output bit |
| tx_free | input | 2x7 | Free entries in each transmit FIFO |
| tx_trig | input | 2x7 | Transmit-ready threshold per channel |
| rx_level | input | 2x7 | Filled entries in each receive FIFO |
| baud_tick | input | 2 | 16x baud clock per channel |
| irq_req | input | 2 | Raw interrupt request per channel |
| wr_stb | output | 2 | Per-channel write strobe |
| rd_stb | output | 2 | Per-channel read strobe |
| reg_addr | output | 3 | Register address for the strobed access |
| reg_wdata | output | 8 | Write data for the strobed write |
| host_rdata | output | 8 | Read data towards the host |
| mf_pin | output | 2 | Multi-function pin per channel |
| txrdy_n | output | 2 | Transmit-ready, active low, per channel |
| irq_out | output | 2 | Gated interrupt per channel |

## Verification
The bench holds each strobe low for several core cycles. A design that pulsed on the level instead of the edge would emit a burst of strobes, and the scoreboard would see extra items. It runs broadcast writes and reads with `chan_sel` at 0. A decoder that ignored the override would strobe only channel B, and one that broadcast reads would strobe both channels. The transmit-ready sequence lowers the free count below the threshold after a full FIFO and again after a ready state. This exposes a plain comparator that skips the hold. All four MF encodings are visited, including the unused one, which would otherwise float to whatever a default branch produced.

// File: rtl/duart_pkg.sv
package duart_pkg;

    localparam int NUM_CH = 2;
    localparam int CH_A   = 0;
    localparam int CH_B   = 1;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int AFR_W  = 3;

    typedef enum logic [1:0] {
        MF_OP    = 2'b00,
        MF_BAUD  = 2'b01,
        MF_RXRDY = 2'b10,
        MF_HIGH  = 2'b11
    } mf_sel_e;

    typedef struct packed {
        logic              cs_n;
        logic              chan_sel;
        logic              rd_n;
        logic              wr_n;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_smp_t;

    localparam bus_smp_t BUS_IDLE = '{cs_n: 1'b1, chan_sel: 1'b0, rd_n: 1'b1,
                                      wr_n: 1'b1, addr: '0, data: '0};

    // Channel mask for a single addressed channel.
    function automatic logic [NUM_CH-1:0] chan_onehot(input logic sel);
        logic [NUM_CH-1:0] m;
        m = '0;
        if (sel) m[CH_A] = 1'b1;
        else     m[CH_B] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/duart_bus_sync.sv
module duart_bus_sync
    import duart_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_smp_t bus_raw,
    output bus_smp_t bus_q,
    output logic     wr_evt,
    output logic     rd_evt
);

    bus_smp_t chain [STAGES];
    logic     rd_prev;
    logic     wr_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) chain[k] <= BUS_IDLE;
            rd_prev <= 1'b1;
            wr_prev <= 1'b1;
        end else begin
            chain[0] <= bus_raw;
            for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
            rd_prev <= chain[STAGES-1].rd_n;
            wr_prev <= chain[STAGES-1].wr_n;
        end
    end

    assign bus_q  = chain[STAGES-1];
    assign wr_evt = bus_q.wr_n & ~wr_prev & ~bus_q.cs_n;
    assign rd_evt = ~bus_q.rd_n & rd_prev & ~bus_q.cs_n;

endmodule

// File: rtl/duart_addr_dec.sv
module duart_addr_dec
    import duart_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  bus_smp_t                      bus_q,
    input  logic                          wr_evt,
    input  logic                          rd_evt,
    input  logic                          bcast,
    input  logic [NUM_CH-1:0][DATA_W-1:0] ch_rdata,
    output logic [NUM_CH-1:0]             wr_stb,
    output logic [NUM_CH-1:0]             rd_stb,
    output logic [ADDR_W-1:0]             reg_addr,
    output logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             host_rdata
);

    logic [NUM_CH-1:0] sel_mask;
    logic [NUM_CH-1:0] wr_mask;
    logic [NUM_CH-1:0] rd_mask;
    logic              rd_active;
    logic              rd_from_a;

    always_comb begin
        sel_mask  = chan_onehot(bus_q.chan_sel);
        wr_mask   = bcast ? '1 : sel_mask;
        rd_mask   = bcast ? chan_onehot(1'b1) : sel_mask;
        rd_from_a = bcast | bus_q.chan_sel;
        rd_active = ~bus_q.rd_n & ~bus_q.cs_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_stb    <= '0;
            rd_stb    <= '0;
            reg_addr  <= '0;
            reg_wdata <= '0;
        end else begin
            wr_stb <= wr_evt ? wr_mask : '0;
            rd_stb <= rd_evt ? rd_mask : '0;
            if (wr_evt || rd_evt) reg_addr <= bus_q.addr;
            if (wr_evt)           reg_wdata <= bus_q.data;
        end
    end

    always_comb begin
        if (!rd_active)     host_rdata = '0;
        else if (rd_from_a) host_rdata = ch_rdata[CH_A];
        else                host_rdata = ch_rdata[CH_B];
    end

endmodule

// File: rtl/duart_chan_pins.sv
module duart_chan_pins
    import duart_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mf_sel,
    input  logic             mcr_b3,
    input  logic [LVL_W-1:0] tx_free,
    input  logic [LVL_W-1:0] tx_trig,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             baud_tick,
    input  logic             irq_req,
    output logic             mf_q,
    output logic             txrdy_n_q,
    output logic             irq_q
);

    mf_sel_e sel;
    logic    mf_d;

    assign sel = mf_sel_e'(mf_sel);

    always_comb begin
        case (sel)
            MF_OP:    mf_d = ~mcr_b3;
            MF_BAUD:  mf_d = baud_tick;
            MF_RXRDY: mf_d = (rx_level == '0);
            default:  mf_d = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mf_q      <= 1'b0;
            txrdy_n_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            mf_q  <= mf_d;
            irq_q <= irq_req & mcr_b3;
            if (tx_free == '0)          txrdy_n_q <= 1'b1;
            else if (tx_free >= tx_trig) txrdy_n_q <= 1'b0;
        end
    end

endmodule

// File: rtl/duart_host_front.sv
module duart_host_front
    import duart_pkg::*;
#(
    parameter  int FIFO_DEPTH  = 64,
    parameter  int SYNC_STAGES = 2,
    localparam int LVL_W       = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cs_n,
    input  logic                          chan_sel,
    input  logic                          rd_n,
    input  logic                          wr_n,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [NUM_CH-1:0][DATA_W-1:0] ch_rdata,
    input  logic [NUM_CH-1:0][AFR_W-1:0]  afr,
    input  logic [NUM_CH-1:0]             mcr_bit3,
    input  logic [NUM_CH-1:0][LVL_W-1:0]  tx_free,
    input  logic [NUM_CH-1:0][LVL_W-1:0]  tx_trig,
    input  logic [NUM_CH-1:0][LVL_W-1:0]  rx_level,
    input  logic [NUM_CH-1:0]             baud_tick,
    input  logic [NUM_CH-1:0]             irq_req,
    output logic [NUM_CH-1:0]             wr_stb,
    output logic [NUM_CH-1:0]             rd_stb,
    output logic [ADDR_W-1:0]             reg_addr,
    output logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             host_rdata,
    output logic [NUM_CH-1:0]             mf_pin,
    output logic [NUM_CH-1:0]             txrdy_n,
    output logic [NUM_CH-1:0]             irq_out
);

    bus_smp_t bus_raw;
    bus_smp_t bus_q;
    logic     wr_evt;
    logic     rd_evt;
    logic     bcast;

    always_comb begin
        bus_raw.cs_n     = cs_n;
        bus_raw.chan_sel = chan_sel;
        bus_raw.rd_n     = rd_n;
        bus_raw.wr_n     = wr_n;
        bus_raw.addr     = addr;
        bus_raw.data     = wdata;
        bcast = 1'b0;
        for (int c = 0; c < NUM_CH; c++) bcast |= afr[c][0];
    end

    duart_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .bus_raw (bus_raw),
        .bus_q   (bus_q),
        .wr_evt  (wr_evt),
        .rd_evt  (rd_evt)
    );

    duart_addr_dec dec_i (
        .clk        (clk),
        .rst        (rst),
        .bus_q      (bus_q),
        .wr_evt     (wr_evt),
        .rd_evt     (rd_evt),
        .bcast      (bcast),
        .ch_rdata   (ch_rdata),
        .wr_stb     (wr_stb),
        .rd_stb     (rd_stb),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .host_rdata (host_rdata)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        duart_chan_pins #(.LVL_W(LVL_W)) pins_i (
            .clk       (clk),
            .rst       (rst),
            .mf_sel    (afr[c][2:1]),
            .mcr_b3    (mcr_bit3[c]),
            .tx_free   (tx_free[c]),
            .tx_trig   (tx_trig[c]),
            .rx_level  (rx_level[c]),
            .baud_tick (baud_tick[c]),
            .irq_req   (irq_req[c]),
            .mf_q      (mf_pin[c]),
            .txrdy_n_q (txrdy_n[c]),
            .irq_q     (irq_out[c])
        );
    end

endmodule

// File: rtl/duart_host_front_chk.sv
module duart_host_front_chk
    import duart_pkg::*;
#(
    parameter  int FIFO_DEPTH = 64,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NUM_CH-1:0][AFR_W-1:0] afr,
    input logic [NUM_CH-1:0]            mcr_bit3,
    input logic [NUM_CH-1:0][LVL_W-1:0] tx_free,
    input logic [NUM_CH-1:0]            wr_stb,
    input logic [NUM_CH-1:0]            rd_stb,
    input logic [NUM_CH-1:0]            mf_pin,
    input logic [NUM_CH-1:0]            txrdy_n,
    input logic [NUM_CH-1:0]            irq_out
);

    assert_rd_single_ch_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_stb));

    assert_wr_one_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        (|wr_stb) |=> !(|wr_stb));

    assert_rd_one_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        (|rd_stb) |=> !(|rd_stb));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        assert_full_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
            (tx_free[c] == '0) |=> txrdy_n[c]);

        assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
            !mcr_bit3[c] |=> !irq_out[c]);

        assert_mf_unused_high_R6: assert property (@(posedge clk) disable iff (rst)
            (afr[c][2:1] == 2'b11) |=> mf_pin[c]);

        assert_mf_op_low_R7: assert property (@(posedge clk) disable iff (rst)
            (afr[c][2:1] == 2'b00 && mcr_bit3[c]) |=> !mf_pin[c]);
    end

endmodule

bind duart_host_front duart_host_front_chk #(.FIFO_DEPTH(FIFO_DEPTH)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .afr      (afr),
    .mcr_bit3 (mcr_bit3),
    .tx_free  (tx_free),
    .wr_stb   (wr_stb),
    .rd_stb   (rd_stb),
    .mf_pin   (mf_pin),
    .txrdy_n  (txrdy_n),
    .irq_out  (irq_out)
);

// File: tb/duart_host_front_tb_top.sv
module duart_host_front_tb_top;
    import duart_pkg::*;

    localparam int LVL_W = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, chan_sel = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [1:0][7:0] ch_rdata;
    logic [1:0][2:0] afr = '0;
    logic [1:0] mcr_bit3 = 2'b11;
    logic [1:0][LVL_W-1:0] tx_free, tx_trig, rx_level;
    logic [1:0] baud_tick = '0, irq_req = '0;
    logic [1:0] wr_stb, rd_stb, mf_pin, txrdy_n, irq_out;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata, host_rdata;

    int checks = 0;
    int errors = 0;
    int exp_total = 0;
    int obs_total = 0;

    typedef struct {
        logic       is_wr;
        logic [1:0] mask;
        logic [2:0] a;
        logic [7:0] d;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    duart_host_front dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .chan_sel(chan_sel), .rd_n(rd_n),
        .wr_n(wr_n), .addr(addr), .wdata(wdata), .ch_rdata(ch_rdata), .afr(afr),
        .mcr_bit3(mcr_bit3), .tx_free(tx_free), .tx_trig(tx_trig),
        .rx_level(rx_level), .baud_tick(baud_tick), .irq_req(irq_req),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .host_rdata(host_rdata), .mf_pin(mf_pin),
        .txrdy_n(txrdy_n), .irq_out(irq_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Monitor: pops expected strobe items as the design emits them.
    always @(negedge clk) begin
        if (!rst && ((|wr_stb) || (|rd_stb))) begin
            obs_total++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected strobe", {wr_stb, rd_stb}, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.is_wr) begin
                    check(wr_stb == e.mask && rd_stb == 2'b00, "R1/R2 write mask", wr_stb, e.mask);
                    check(reg_addr == e.a && reg_wdata == e.d, "R3 write addr/data",
                          {reg_addr, reg_wdata}, {e.a, e.d});
                end else begin
                    check(rd_stb == e.mask && wr_stb == 2'b00, "R4/R5 read mask", rd_stb, e.mask);
                    check(reg_addr == e.a, "R4 read addr", reg_addr, e.a);
                end
            end
        end
    end

    task automatic do_write(input logic csn, input logic sel, input logic [2:0] a,
                            input logic [7:0] d, input logic [1:0] mask, input string req);
        @(negedge clk);
        cs_n = csn; chan_sel = sel; addr = a; wdata = d;
        repeat (2) @(negedge clk);
        wr_n = 1'b0;
        if (mask != 2'b00) begin
            exp_q.push_back('{1'b1, mask, a, d});
            exp_total++;
        end
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        check(obs_total == exp_total, req, obs_total, exp_total);
    endtask

    task automatic do_read(input logic csn, input logic sel, input logic [2:0] a,
                           input logic [1:0] mask, input logic [7:0] exp_d, input string req);
        @(negedge clk);
        cs_n = csn; chan_sel = sel; addr = a;
        repeat (2) @(negedge clk);
        rd_n = 1'b0;
        if (mask != 2'b00) begin
            exp_q.push_back('{1'b0, mask, a, 8'h00});
            exp_total++;
        end
        repeat (5) @(negedge clk);
        check(host_rdata == exp_d, req, host_rdata, exp_d);
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
        check(host_rdata == 8'h00, "R4 rdata idle", host_rdata, 0);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        check(obs_total == exp_total, req, obs_total, exp_total);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        ch_rdata[0] = 8'hA5;
        ch_rdata[1] = 8'h3C;
        tx_free  = '{7'd64, 7'd64};
        tx_trig  = '{7'd16, 7'd16};
        rx_level = '{7'd0, 7'd0};
        irq_req  = 2'b11;

        // R11/R10 reset state
        repeat (4) @(negedge clk);
        check(wr_stb == 0 && rd_stb == 0, "R11 strobes in reset", {wr_stb, rd_stb}, 0);
        check(host_rdata == 0, "R11 rdata in reset", host_rdata, 0);
        check(mf_pin == 2'b00 && txrdy_n == 2'b00, "R11 pins in reset", {mf_pin, txrdy_n}, 0);
        check(irq_out == 2'b00, "R10 irq low in reset", irq_out, 0);
        irq_req = 2'b00;
        rst = 1'b0;
        settle();

        // R1, R3: channel decode
        do_write(1'b0, 1'b1, 3'd3, 8'h5A, 2'b01, "R1 write A count");
        do_write(1'b0, 1'b0, 3'd6, 8'hC3, 2'b10, "R1 write B count");
        do_write(1'b1, 1'b1, 3'd2, 8'h11, 2'b00, "R1 cs high no write");
        do_write(1'b0, 1'b1, 3'd0, 8'hFF, 2'b01, "R3 write second A");

        // R4: reads
        do_read(1'b0, 1'b1, 3'd5, 2'b01, 8'hA5, "R4 read A");
        do_read(1'b0, 1'b0, 3'd1, 2'b10, 8'h3C, "R4 read B");
        do_read(1'b1, 1'b0, 3'd1, 2'b00, 8'h00, "R1 cs high no read");

        // R2, R5: broadcast
        afr[1] = 3'b001;
        do_write(1'b0, 1'b0, 3'd4, 8'h77, 2'b11, "R2 broadcast write");
        do_read(1'b0, 1'b0, 3'd4, 2'b01, 8'hA5, "R5 broadcast read A");
        afr[1] = 3'b000;
        do_write(1'b0, 1'b0, 3'd7, 8'h01, 2'b10, "R2 broadcast off");

        // R6, R7: OP mode and unused encoding
        mcr_bit3 = 2'b01; settle();
        check(mf_pin == 2'b10, "R7 OP follows mcr", mf_pin, 2'b10);
        afr[0] = 3'b110; settle();
        check(mf_pin[0] == 1'b1, "R6 unused code high", mf_pin[0], 1);
        // baud tick routing
        afr[0] = 3'b010; baud_tick = 2'b01; settle();
        check(mf_pin[0] == 1'b1, "R6 baud high", mf_pin[0], 1);
        baud_tick = 2'b00; settle();
        check(mf_pin[0] == 1'b0, "R6 baud low", mf_pin[0], 0);
        // R8 receive-ready
        afr[0] = 3'b100; settle();
        check(mf_pin[0] == 1'b1, "R8 rx empty high", mf_pin[0], 1);
        rx_level[0] = 7'd3; settle();
        check(mf_pin[0] == 1'b0, "R8 rx data low", mf_pin[0], 0);
        afr[0] = 3'b000; mcr_bit3 = 2'b11;

        // R9 transmit-ready hysteresis
        tx_free[0] = 7'd0; settle();
        check(txrdy_n[0] == 1'b1, "R9 full high", txrdy_n[0], 1);
        tx_free[0] = 7'd10; settle();
        check(txrdy_n[0] == 1'b1, "R9 below trig hold high", txrdy_n[0], 1);
        tx_free[0] = 7'd16; settle();
        check(txrdy_n[0] == 1'b0, "R9 at trig low", txrdy_n[0], 0);
        tx_free[0] = 7'd10; settle();
        check(txrdy_n[0] == 1'b0, "R9 below trig hold low", txrdy_n[0], 0);
        tx_free[0] = 7'd0; settle();
        check(txrdy_n[0] == 1'b1, "R9 full again", txrdy_n[0], 1);
        check(txrdy_n[1] == 1'b0, "R9 other channel", txrdy_n[1], 0);

        // R10 interrupt gating
        irq_req = 2'b11; mcr_bit3 = 2'b10; settle();
        check(irq_out == 2'b10, "R10 irq gated", irq_out, 2'b10);
        mcr_bit3 = 2'b11; settle();
        check(irq_out == 2'b11, "R10 irq passes", irq_out, 2'b11);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule